// File: doc/BRIEF.md
# Dual-Address Operand Mover

This block carries one operand per request from a source location to a destination location over a single shared bus on which it is the master. Each operand is first fetched from the source with bus cycles as wide as the source port, then stored at the destination with bus cycles as wide as the destination port. The operand is as wide as the wider of the two ports. A wide fetch is split into several narrow stores, and several narrow fetches are packed into one wide store. An operand therefore needs between two and five bus cycles.

The block holds the bus from its first fetch until its last store is acknowledged. Any request that arrives in that time is ignored. Only a bus error ends an operand early. In that case the bus is released at once, and a status bit tells whether the failing cycle was a fetch or a store. Both addresses advance by the size of every cycle that completes, so the surrounding channel logic can read back where the next operand starts.

Top module: `dma_mover`

## Requirements
- R1: When `req` is high while `busy` is low, the request is accepted at that clock edge. On the next cycle `busy` and `bus_req` are high, `bus_we` is low, `bus_addr` equals the sampled `src_addr`, and `bus_size` carries the source size code. The size codes are 0 for 8 bits and 1 for 16 bits. Codes 2 and 3 both mean 32 bits.
- R2: The operand width is the wider of the two port sizes. The block first makes operand/source-width fetches, at `src_addr` plus the source width times the fetch index. It then makes operand/destination-width stores, at `dst_addr` plus the destination width times the store index. No fetch follows a store within one operand.
- R3: When both port sizes are equal, the operand takes exactly one fetch and one store, and `done` follows the acknowledge of that single store.
- R4: Fetch data is right-justified on `bus_rdata`, and the lanes above the fetch width are ignored. The first fetch becomes the most significant part of the operand. Stores present the most significant part first, right-justified on `bus_wdata`, with zeros above the store width.
- R5: While `busy` is high, `req` and all request inputs are ignored. `bus_req` stays high without a gap between cycles. `bus_addr`, `bus_we`, `bus_size` and `bus_wdata` hold steady until `bus_ack` or `bus_berr`. A request that arrives in the cycle of the final store acknowledge does not start a new operand.
- R6: `bus_berr` during any cycle aborts the operand at that edge, and it wins over a simultaneous `bus_ack`. On the next cycle `busy` and `bus_req` are low, `err` pulses for one cycle, `done` stays low, and `err_in_write` is 1 for a store failure or 0 for a fetch failure. `err_in_write` holds until the next accepted request.
- R7: One cycle after the final store acknowledge, `done` pulses for one cycle and `busy` is low. At that point `next_src` and `next_dst` equal the starting addresses plus the operand width in bytes.
- R8: After reset `busy`, `bus_req`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Operand transfer request |
| src_addr | input | ADDR_W | Source byte address, sampled on accept |
| dst_addr | input | ADDR_W | Destination byte address, sampled on accept |
| src_size | input | 2 | Source port size code |
| dst_size | input | 2 | Destination port size code |
| busy | output | 1 | Operand in progress, bus held |
| done | output | 1 | One-cycle pulse on normal completion |
| err | output | 1 | One-cycle pulse on bus-error abort |
| err_in_write | output | 1 | Failing cycle was a store |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = store, 0 = fetch |
| bus_addr | output | ADDR_W | Bus cycle byte address |
| bus_size | output | 2 | Bus cycle size code |
| bus_wdata | output | 32 | Store data, right-justified |
| bus_rdata | input | 32 | Fetch data, right-justified |
| bus_ack | input | 1 | Cycle acknowledge |
| bus_berr | input | 1 | Cycle bus error |
| next_src | output | ADDR_W | Advanced source address |
| next_dst | output | ADDR_W | Advanced destination address |

## Verification
Two events can land on the same edge. One is the acknowledge of the last store together with a fresh `req`. The other is `bus_ack` together with `bus_berr`. The bench holds `req` high with altered addresses and sizes through every operand, including the final acknowledge edge. It then checks that the operand completes with the sampled values and that the bus stays idle on the cycle after `done`. In one abort case the bench drives acknowledge and error in the same cycle, and it judges the result by `err`, `err_in_write` and the absence of `done`.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int CNT_W  = $clog2(LANES) + 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_FULL = 2'd2
    } xfer_size_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    function automatic xfer_size_e decode_size(input logic [1:0] code);
        case (code)
            2'd0:    return SZ_BYTE;
            2'd1:    return SZ_HALF;
            default: return SZ_FULL;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] size_bytes(input xfer_size_e s);
        case (s)
            SZ_BYTE: return CNT_W'(1);
            SZ_HALF: return CNT_W'(2);
            default: return CNT_W'(4);
        endcase
    endfunction

    function automatic xfer_size_e wider(input xfer_size_e a, input xfer_size_e b);
        return (a > b) ? a : b;
    endfunction

    // number of bus cycles of width 'port' needed to cover an operand of width 'op'
    function automatic logic [CNT_W-1:0] beat_count(input xfer_size_e op, input xfer_size_e port);
        logic [1:0] diff;
        diff = 2'(op) - 2'(port);
        return CNT_W'(1) << diff;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input xfer_size_e s);
        case (s)
            SZ_BYTE: return DATA_W'(32'h0000_00FF);
            SZ_HALF: return DATA_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/dma_mover_ctrl.sv
module dma_mover_ctrl
    import dma_mover_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [1:0]       src_code,
    input  logic [1:0]       dst_code,
    input  logic             bus_ack,
    input  logic             bus_berr,
    output phase_e           phase,
    output logic             load,
    output logic             rd_step,
    output logic             wr_step,
    output xfer_size_e       rd_size,
    output xfer_size_e       wr_size,
    output logic [CNT_W-1:0] wr_left,
    output logic             done,
    output logic             err,
    output logic             err_in_write
);

    phase_e           phase_q;
    logic [CNT_W-1:0] rd_left_q;
    logic [CNT_W-1:0] wr_left_q;
    xfer_size_e       rd_size_q;
    xfer_size_e       wr_size_q;
    logic             done_q;
    logic             err_q;
    logic             err_wr_q;

    xfer_size_e       src_sz;
    xfer_size_e       dst_sz;
    xfer_size_e       op_sz;
    logic             abort;

    always_comb begin
        src_sz  = decode_size(src_code);
        dst_sz  = decode_size(dst_code);
        op_sz   = wider(src_sz, dst_sz);
        load    = (phase_q == PH_IDLE) && req;
        abort   = (phase_q != PH_IDLE) && bus_berr;
        rd_step = (phase_q == PH_READ)  && bus_ack && !bus_berr;
        wr_step = (phase_q == PH_WRITE) && bus_ack && !bus_berr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            rd_left_q <= '0;
            wr_left_q <= '0;
            rd_size_q <= SZ_BYTE;
            wr_size_q <= SZ_BYTE;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            err_wr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (load) begin
                rd_size_q <= src_sz;
                wr_size_q <= dst_sz;
                rd_left_q <= beat_count(op_sz, src_sz);
                wr_left_q <= beat_count(op_sz, dst_sz);
                err_wr_q  <= 1'b0;
                phase_q   <= PH_READ;
            end else if (abort) begin
                phase_q  <= PH_IDLE;
                err_q    <= 1'b1;
                err_wr_q <= (phase_q == PH_WRITE);
            end else if (rd_step) begin
                rd_left_q <= rd_left_q - CNT_W'(1);
                if (rd_left_q == CNT_W'(1)) begin
                    phase_q <= PH_WRITE;
                end
            end else if (wr_step) begin
                wr_left_q <= wr_left_q - CNT_W'(1);
                if (wr_left_q == CNT_W'(1)) begin
                    phase_q <= PH_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign phase        = phase_q;
    assign rd_size      = rd_size_q;
    assign wr_size      = wr_size_q;
    assign wr_left      = wr_left_q;
    assign done         = done_q;
    assign err          = err_q;
    assign err_in_write = err_wr_q;

endmodule

// File: rtl/dma_mover_addr.sv
module dma_mover_addr
    import dma_mover_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    input  xfer_size_e        size,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= base;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(size_bytes(size));
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/dma_mover_hold.sv
module dma_mover_hold
    import dma_mover_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              capture,
    input  xfer_size_e        rd_size,
    input  logic [DATA_W-1:0] rdata,
    input  xfer_size_e        wr_size,
    input  logic [CNT_W-1:0]  wr_left,
    output logic [DATA_W-1:0] wdata
);

    localparam int SH_W = 2 * CNT_W + 3;

    logic [DATA_W-1:0] hold_q;
    logic [CNT_W+2:0]  shift_in;
    logic [2*CNT_W-1:0] slot;
    logic [SH_W-1:0]   shift_out;

    // earlier fetches move up as later ones arrive
    always_comb begin
        shift_in = {size_bytes(rd_size), 3'b000};
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hold_q <= '0;
        end else if (capture) begin
            hold_q <= (hold_q << shift_in) | (rdata & lane_mask(rd_size));
        end
    end

    // remaining-store count picks which slice of the operand goes out next
    always_comb begin
        if (wr_left == '0) begin
            slot = '0;
        end else begin
            slot = {{CNT_W{1'b0}}, size_bytes(wr_size)} *
                   {{CNT_W{1'b0}}, wr_left - CNT_W'(1)};
        end
        shift_out = {slot, 3'b000};
        wdata     = (hold_q >> shift_out) & lane_mask(wr_size);
    end

endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_mover_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [1:0]        src_size,
    input  logic [1:0]        dst_size,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              err_in_write,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_berr,
    output logic [ADDR_W-1:0] next_src,
    output logic [ADDR_W-1:0] next_dst
);

    localparam int N_PORTS = 2;
    localparam int P_SRC   = 0;
    localparam int P_DST   = 1;

    typedef struct packed {
        logic              active;
        logic              we;
        xfer_size_e        size;
        logic [ADDR_W-1:0] addr;
    } bus_cmd_t;

    phase_e            phase;
    logic              load;
    logic              rd_step;
    logic              wr_step;
    xfer_size_e        rd_size;
    xfer_size_e        wr_size;
    logic [CNT_W-1:0]  wr_left;
    logic [DATA_W-1:0] wdata;

    logic [ADDR_W-1:0] base_v [N_PORTS];
    logic [ADDR_W-1:0] addr_v [N_PORTS];
    xfer_size_e        size_v [N_PORTS];
    logic [N_PORTS-1:0] step_v;
    bus_cmd_t          cmd;

    dma_mover_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .src_code     (src_size),
        .dst_code     (dst_size),
        .bus_ack      (bus_ack),
        .bus_berr     (bus_berr),
        .phase        (phase),
        .load         (load),
        .rd_step      (rd_step),
        .wr_step      (wr_step),
        .rd_size      (rd_size),
        .wr_size      (wr_size),
        .wr_left      (wr_left),
        .done         (done),
        .err          (err),
        .err_in_write (err_in_write)
    );

    always_comb begin
        base_v[P_SRC] = src_addr;
        base_v[P_DST] = dst_addr;
        size_v[P_SRC] = rd_size;
        size_v[P_DST] = wr_size;
        step_v[P_SRC] = rd_step;
        step_v[P_DST] = wr_step;
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        dma_mover_addr #(.ADDR_W(ADDR_W)) u_addr (
            .clk  (clk),
            .rst  (rst),
            .load (load),
            .base (base_v[p]),
            .step (step_v[p]),
            .size (size_v[p]),
            .addr (addr_v[p])
        );
    end

    dma_mover_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .clear   (load),
        .capture (rd_step),
        .rd_size (rd_size),
        .rdata   (bus_rdata),
        .wr_size (wr_size),
        .wr_left (wr_left),
        .wdata   (wdata)
    );

    always_comb begin
        cmd.active = (phase != PH_IDLE);
        cmd.we     = (phase == PH_WRITE);
        cmd.size   = cmd.we ? wr_size : rd_size;
        cmd.addr   = cmd.we ? addr_v[P_DST] : addr_v[P_SRC];
    end

    assign busy      = cmd.active;
    assign bus_req   = cmd.active;
    assign bus_we    = cmd.we;
    assign bus_addr  = cmd.addr;
    assign bus_size  = cmd.size;
    assign bus_wdata = cmd.we ? wdata : '0;
    assign next_src  = addr_v[P_SRC];
    assign next_dst  = addr_v[P_DST];

endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              err_in_write,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [31:0]       bus_wdata,
    input logic              bus_ack,
    input logic              bus_berr
);

    p_accept_starts_fetch_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && req) |=> (busy && bus_req && !bus_we));

    p_no_fetch_after_store_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |=> (!bus_req || bus_we));

    p_cycle_held_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack && !bus_berr) |=>
        (bus_req && $stable(bus_addr) && $stable(bus_we) &&
         $stable(bus_size) && $stable(bus_wdata)));

    p_berr_aborts_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_berr) |=> (!busy && !bus_req && err && !done));

    p_err_side_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_berr) |=> (err_in_write == $past(bus_we)));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !err));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind dma_mover dma_mover_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .err_in_write (err_in_write),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_size     (bus_size),
    .bus_wdata    (bus_wdata),
    .bus_ack      (bus_ack),
    .bus_berr     (bus_berr)
);

// File: tb/dma_mover_test.sv
module dma_mover_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [31:0] src_addr = '0;
    logic [31:0] dst_addr = '0;
    logic [1:0]  src_size = '0;
    logic [1:0]  dst_size = '0;
    logic        busy, done, err, err_in_write;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack  = 1'b0;
    logic        bus_berr = 1'b0;
    logic [31:0] next_src, next_dst;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dma_mover #(.ADDR_W(32)) uut (
        .clk(clk), .rst(rst), .req(req), .src_addr(src_addr), .dst_addr(dst_addr),
        .src_size(src_size), .dst_size(dst_size), .busy(busy), .done(done), .err(err),
        .err_in_write(err_in_write), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_berr(bus_berr),
        .next_src(next_src), .next_dst(next_dst)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // modelled memory contents: one byte per address
    function automatic logic [7:0] mem_at(input logic [31:0] a);
        return (a[7:0] * 8'd3) ^ 8'h5C;
    endfunction

    // big-endian value of n bytes starting at a, right-justified
    function automatic logic [31:0] mem_val(input logic [31:0] a, input int n);
        logic [31:0] v = '0;
        for (int i = 0; i < n; i++) v = (v << 8) | 32'(mem_at(a + 32'(i)));
        return v;
    endfunction

    function automatic int width_of(input logic [1:0] code);
        return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [1:0] norm_code(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    // fail_at: index of the bus cycle answered with an error, -1 for none
    task automatic run_op(input logic [31:0] s, input logic [31:0] d,
                          input logic [1:0] sc, input logic [1:0] dc,
                          input int fail_at, input bit ack_too);
        int rb = width_of(sc);
        int wb = width_of(dc);
        int ob = (rb > wb) ? rb : wb;
        int nr = ob / rb;
        int nw = ob / wb;
        logic [31:0] opval = mem_val(s, ob);
        bit aborted = 1'b0;

        @(negedge clk);
        check("R5", "busy before request", 32'(busy), 32'd0);
        src_addr = s; dst_addr = d; src_size = sc; dst_size = dc; req = 1'b1;
        @(negedge clk);
        // keep req high with other values: all must be ignored while busy
        src_addr = ~s; dst_addr = ~d; src_size = ~sc; dst_size = ~dc;

        for (int k = 0; k < nr + nw && !aborted; k++) begin
            bit          is_wr    = (k >= nr);
            int          j        = is_wr ? k - nr : k;
            int          bw       = is_wr ? wb : rb;
            logic [31:0] exp_addr = is_wr ? d + 32'(j * wb) : s + 32'(j * rb);
            logic [1:0]  exp_size = is_wr ? norm_code(dc) : norm_code(sc);
            logic [31:0] mask     = (bw == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * bw)) - 32'h1);
            logic [31:0] exp_wd   = (opval >> (8 * (ob - (j + 1) * wb))) & mask;
            int          waits    = (k + int'(s[1:0])) % 3;
            string       tag      = (k == 0) ? "R1" : "R2";

            for (int w = 0; w <= waits; w++) begin
                check(w == 0 ? tag : "R5", "bus_req", 32'(bus_req), 32'd1);
                check(w == 0 ? tag : "R5", "busy", 32'(busy), 32'd1);
                check(w == 0 ? tag : "R5", "bus_we", 32'(bus_we), 32'(is_wr));
                check(w == 0 ? tag : "R5", "bus_addr", bus_addr, exp_addr);
                check(w == 0 ? tag : "R5", "bus_size", 32'(bus_size), 32'(exp_size));
                if (is_wr) check("R4", "bus_wdata", bus_wdata, exp_wd);
                if (w < waits) @(negedge clk);
            end

            if (k == fail_at) begin
                bus_berr = 1'b1;
                bus_ack  = ack_too;
            end else begin
                bus_ack = 1'b1;
            end
            if (is_wr) bus_rdata = 32'hDEAD_BEEF;
            else bus_rdata = mem_val(exp_addr, rb) | (32'hC3C3_C3C3 & ~mask);
            @(negedge clk);
            bus_ack = 1'b0; bus_berr = 1'b0; bus_rdata = 32'h0BAD_F00D;

            if (k == fail_at) begin
                aborted = 1'b1;
                check("R6", "err", 32'(err), 32'd1);
                check("R6", "done", 32'(done), 32'd0);
                check("R6", "busy", 32'(busy), 32'd0);
                check("R6", "bus_req", 32'(bus_req), 32'd0);
                check("R6", "err_in_write", 32'(err_in_write), 32'(is_wr));
            end
        end

        if (!aborted) begin
            string dtag = (nr + nw == 2) ? "R3" : "R7";
            check(dtag, "done", 32'(done), 32'd1);
            check("R7", "busy", 32'(busy), 32'd0);
            check("R7", "err", 32'(err), 32'd0);
            check("R7", "next_src", next_src, s + 32'(ob));
            check("R7", "next_dst", next_dst, d + 32'(ob));
        end
        req = 1'b0;
        @(negedge clk);
        check("R5", "no restart bus_req", 32'(bus_req), 32'd0);
        check("R7", "done single cycle", 32'(done), 32'd0);
        check("R6", "err single cycle", 32'(err), 32'd0);
        if (aborted) check("R6", "err_in_write held", 32'(err_in_write), 32'(fail_at >= nr));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8", "busy after reset", 32'(busy), 32'd0);
        check("R8", "bus_req after reset", 32'(bus_req), 32'd0);
        check("R8", "done after reset", 32'(done), 32'd0);
        check("R8", "err after reset", 32'(err), 32'd0);

        // equal sizes: one fetch, one store
        run_op(32'h0000_1000, 32'h0000_2000, 2'd0, 2'd0, -1, 1'b0);
        run_op(32'h0000_1102, 32'h0000_2206, 2'd1, 2'd1, -1, 1'b0);
        run_op(32'h0000_1208, 32'h0000_2310, 2'd2, 2'd2, -1, 1'b0);
        run_op(32'h0000_1304, 32'h0000_2404, 2'd3, 2'd2, -1, 1'b0);
        // split and pack
        run_op(32'h0000_3010, 32'h0000_4001, 2'd2, 2'd0, -1, 1'b0);
        run_op(32'h0000_3101, 32'h0000_4120, 2'd0, 2'd2, -1, 1'b0);
        run_op(32'h0000_3202, 32'h0000_4203, 2'd1, 2'd0, -1, 1'b0);
        run_op(32'h0000_3303, 32'h0000_4302, 2'd0, 2'd1, -1, 1'b0);
        run_op(32'h0000_3400, 32'h0000_4402, 2'd2, 2'd1, -1, 1'b0);
        run_op(32'h0000_3506, 32'h0000_4508, 2'd1, 2'd2, -1, 1'b0);
        // aborts: fetch phase, store phase with ack and error together, first store
        run_op(32'h0000_5001, 32'h0000_6000, 2'd0, 2'd2, 2, 1'b0);
        run_op(32'h0000_5104, 32'h0000_6103, 2'd2, 2'd0, 3, 1'b1);
        run_op(32'h0000_5202, 32'h0000_6201, 2'd1, 2'd0, 1, 1'b0);
        run_op(32'h0000_5300, 32'h0000_6300, 2'd2, 2'd2, 0, 1'b1);
        // normal operation after an abort
        run_op(32'h0000_7000, 32'h0000_8001, 2'd2, 2'd0, -1, 1'b0);

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule